// File: doc/BRIEF.md
# Status Frame Parity Qualifier

This block sits on the transmit-side status channel of a packet interface. The far end reports flow-control credit for every port as a stream of 2-bit words. The words are organised in frames: a framing word, then a calendar of ports repeated a programmable number of times, then a 2-bit diagonal parity word. The block tracks where each word falls in the calendar and checks the parity word. It then decides when each port's status reaches the transmit scheduler and the user logic, using one shared per-port update strobe.

Two release policies can be picked at run time. The cautious policy holds the final calendar pass of a frame and releases it only after the parity word matches. On a mismatch it drops the whole frame, so no credit is granted from it. The fast policy forwards every entry as soon as it is sampled and only flags a parity mismatch. The block also keeps the last delivered status of each port. From that table it drives a single stop signal that halts every port while any port is full, unless back-pressure is being ignored.

Neither stream has back-pressure. The status line cannot pause, so the input has a valid qualifier and no ready. The update output has no ready either: a strobe is present for exactly one cycle and the consumer must take it in that cycle.

Top module: `stat_qualifier`

## Requirements
- R1: Status words decode as 00 starving, 01 hungry, 10 satisfied. A word of 11 with `st_dip` low is a framing word: it opens a frame and sets the calendar position to port 0. The n-th status word after it (counting from 0) belongs to port n mod (`cal_len_m1`+1). A status word that arrives while no frame is open (before any framing word, or after a parity word) produces no update.
- R2: With `mode_pess` low, each status word in an open frame appears on `upd_valid`/`upd_port`/`upd_stat` right after the clock edge that samples it.
- R3: With `mode_pess` low, a parity mismatch raises `dip_err` but every update of that frame is still delivered unchanged.
- R4: The parity accumulator is set to 11 by the framing word. Each status word w changes it to {acc[0],acc[1]} XOR w. A parity word matches only when it equals the bitwise inverse of the accumulator and exactly (`cal_len_m1`+1)×(`cal_mult_m1`+1) status words have been counted since the framing word. Any other parity word, including one with no open frame, is an error.
- R5: `dip_seen` pulses for one cycle right after the edge that samples any parity word, in both modes. `dip_err` pulses in the same cycle when that parity word is an error, and never at any other time.
- R6: With `mode_pess` high, no update is emitted while a frame is being received. After a matching parity word, ports 0 to `cal_len_m1` are released in ascending order, one per cycle. Each carries the value it received in the last calendar pass, and port 0 appears one cycle after `dip_seen`.
- R7: With `mode_pess` high, a mismatching parity word releases nothing, and the per-port table (and thus `stop_all`) keeps its previous state.
- R8: `stop_all` is high when `ignore_bp` is low and any port from 0 to `cal_len_m1` was last delivered as satisfied. It changes in the same cycle as the update that causes the change.
- R9: While `ignore_bp` is high, `stop_all` is low.
- R10: After reset, `upd_valid`, `dip_seen`, `dip_err` and `stop_all` are low, every port reads as starving, and no frame is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Status clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_pess | input | 1 | 1: hold until parity matches; 0: forward at once |
| ignore_bp | input | 1 | 1: never assert `stop_all` |
| cal_len_m1 | input | 4 | Calendar length minus one (1 to 16 ports) |
| cal_mult_m1 | input | 2 | Calendar repetitions per frame minus one (1 to 4) |
| st_valid | input | 1 | A status-channel word is present this cycle |
| st_word | input | 2 | Status-channel word |
| st_dip | input | 1 | The present word is the frame's parity word |
| upd_valid | output | 1 | Per-port status update strobe |
| upd_port | output | 4 | Port the update belongs to |
| upd_stat | output | 2 | Status value of the update |
| dip_seen | output | 1 | A parity word has been received |
| dip_err | output | 1 | The received parity word did not match |
| stop_all | output | 1 | Stop sending on every port |

## Verification
The hardest case to reach from the ports is a parity word that matches bit for bit but closes a frame of the wrong length. The length check is only visible if the parity itself is right. The bench therefore builds the parity from the words it actually sends in a frame that is one word short, and expects an error with no release. A second case needs set-up: in the cautious mode, checking that a dropped frame leaves the port table untouched only works if the table already holds a satisfied port. So a good frame first sets `stop_all`, and the following bad frame, made of all starving words, must leave it high.

// File: rtl/stq_pkg.sv
package stq_pkg;

  typedef enum logic [1:0] {
    ST_STARVING  = 2'b00,
    ST_HUNGRY    = 2'b01,
    ST_SATISFIED = 2'b10,
    ST_FRAMING   = 2'b11
  } stat_e;

  // One step of the diagonal parity: swap the two lanes, then fold in the word.
  function automatic logic [1:0] dip_step(input logic [1:0] acc, input logic [1:0] w);
    return {acc[0], acc[1]} ^ w;
  endfunction

endpackage

// File: rtl/stq_frame_tracker.sv
module stq_frame_tracker #(
  parameter int MAX_PORTS = 16,
  parameter int MAX_MULT  = 4,
  localparam int PW = $clog2(MAX_PORTS),
  localparam int MW = $clog2(MAX_MULT),
  localparam int CW = $clog2(MAX_PORTS * MAX_MULT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          is_frm,
  input  logic          is_ent,
  input  logic          is_dip,
  input  logic [1:0]    word,
  input  logic [PW-1:0] cal_len_m1,
  input  logic [MW-1:0] cal_mult_m1,
  output logic          in_frame,
  output logic [PW-1:0] pos,
  output logic          dip_good
);
  import stq_pkg::*;

  logic          in_frame_q;
  logic [PW-1:0] pos_q;
  logic [CW-1:0] cnt_q;
  logic [1:0]    acc_q;
  logic [CW-1:0] exp_cnt;

  assign exp_cnt = CW'((32'(cal_len_m1) + 32'd1) * (32'(cal_mult_m1) + 32'd1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_frame_q <= 1'b0;
      pos_q      <= '0;
      cnt_q      <= '0;
      acc_q      <= 2'b11;
    end else if (is_frm) begin
      in_frame_q <= 1'b1;
      pos_q      <= '0;
      cnt_q      <= '0;
      acc_q      <= 2'b11;
    end else if (is_ent) begin
      pos_q <= (pos_q >= cal_len_m1) ? '0 : pos_q + 1'b1;
      if (cnt_q != {CW{1'b1}}) cnt_q <= cnt_q + 1'b1;
      acc_q <= dip_step(acc_q, word);
    end else if (is_dip) begin
      in_frame_q <= 1'b0;
    end
  end

  assign in_frame = in_frame_q;
  assign pos      = pos_q;
  assign dip_good = in_frame_q && (word == ~acc_q) && (cnt_q == exp_cnt);

  AST_FRAME_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    is_frm |=> (in_frame && pos == '0));  // R1
endmodule

// File: rtl/stq_hold_bank.sv
module stq_hold_bank #(
  parameter int MAX_PORTS = 16,
  localparam int PW = $clog2(MAX_PORTS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          is_ent,
  input  logic [PW-1:0] pos,
  input  logic [1:0]    word,
  input  logic          load,
  input  logic [PW-1:0] cal_len_m1,
  output logic          rel_valid,
  output logic [PW-1:0] rel_port,
  output logic [1:0]    rel_stat
);
  logic [1:0]    cap_q  [MAX_PORTS];
  logic [1:0]    bank_q [MAX_PORTS];
  logic          rp_active_q;
  logic [PW-1:0] rp_idx_q;

  for (genvar i = 0; i < MAX_PORTS; i++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cap_q[i]  <= 2'b00;
        bank_q[i] <= 2'b00;
      end else begin
        if (is_ent && pos == PW'(i)) cap_q[i] <= word;
        if (load) bank_q[i] <= cap_q[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rp_active_q <= 1'b0;
      rp_idx_q    <= '0;
    end else if (load) begin
      rp_active_q <= 1'b1;
      rp_idx_q    <= '0;
    end else if (rp_active_q) begin
      if (rp_idx_q >= cal_len_m1) rp_active_q <= 1'b0;
      else                        rp_idx_q    <= rp_idx_q + 1'b1;
    end
  end

  assign rel_valid = rp_active_q;
  assign rel_port  = rp_idx_q;
  assign rel_stat  = bank_q[rp_idx_q];

  AST_REPLAY_FROM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rel_valid) |-> (rel_port == '0));  // R6
endmodule

// File: rtl/stq_port_table.sv
module stq_port_table #(
  parameter int MAX_PORTS = 16,
  localparam int PW = $clog2(MAX_PORTS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [PW-1:0] wr_port,
  input  logic [1:0]    wr_stat,
  input  logic [PW-1:0] cal_len_m1,
  input  logic          ignore_bp,
  output logic          stop_all
);
  import stq_pkg::*;

  logic [1:0]           tbl_q [MAX_PORTS];
  logic [MAX_PORTS-1:0] sat;

  for (genvar i = 0; i < MAX_PORTS; i++) begin : g_port
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          tbl_q[i] <= ST_STARVING;
      else if (wr_en && wr_port == PW'(i)) tbl_q[i] <= wr_stat;
    end
    assign sat[i] = (tbl_q[i] == ST_SATISFIED) &&
                    ((PW+1)'(i) <= {1'b0, cal_len_m1});
  end

  assign stop_all = !ignore_bp && (|sat);

  AST_IGNORE_QUIETS: assert property (@(posedge clk) disable iff (!rst_n)
    ignore_bp |-> !stop_all);  // R9
endmodule

// File: rtl/stat_qualifier.sv
module stat_qualifier #(
  parameter int MAX_PORTS = 16,
  parameter int MAX_MULT  = 4,
  localparam int PW = $clog2(MAX_PORTS),
  localparam int MW = $clog2(MAX_MULT)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_pess,
  input  logic          ignore_bp,
  input  logic [PW-1:0] cal_len_m1,
  input  logic [MW-1:0] cal_mult_m1,
  input  logic          st_valid,
  input  logic [1:0]    st_word,
  input  logic          st_dip,
  output logic          upd_valid,
  output logic [PW-1:0] upd_port,
  output logic [1:0]    upd_stat,
  output logic          dip_seen,
  output logic          dip_err,
  output logic          stop_all
);
  import stq_pkg::*;

  logic          is_frm, is_ent, is_dip, raw_ent;
  logic          in_frame, dip_good;
  logic [PW-1:0] pos;
  logic          rel_valid;
  logic [PW-1:0] rel_port;
  logic [1:0]    rel_stat;
  logic          nxt_valid;
  logic [PW-1:0] nxt_port;
  logic [1:0]    nxt_stat;

  // Word classification
  assign is_dip  = st_valid && st_dip;
  assign is_frm  = st_valid && !st_dip && (st_word == ST_FRAMING);
  assign raw_ent = st_valid && !st_dip && (st_word != ST_FRAMING);
  assign is_ent  = raw_ent && in_frame;

  stq_frame_tracker #(.MAX_PORTS(MAX_PORTS), .MAX_MULT(MAX_MULT)) u_track (
    .clk(clk), .rst_n(rst_n), .is_frm(is_frm), .is_ent(is_ent), .is_dip(is_dip),
    .word(st_word), .cal_len_m1(cal_len_m1), .cal_mult_m1(cal_mult_m1),
    .in_frame(in_frame), .pos(pos), .dip_good(dip_good)
  );

  stq_hold_bank #(.MAX_PORTS(MAX_PORTS)) u_hold (
    .clk(clk), .rst_n(rst_n), .is_ent(is_ent), .pos(pos), .word(st_word),
    .load(is_dip && dip_good && mode_pess), .cal_len_m1(cal_len_m1),
    .rel_valid(rel_valid), .rel_port(rel_port), .rel_stat(rel_stat)
  );

  // Replay has priority; the fast path only runs in forward mode.
  always_comb begin
    if (rel_valid) begin
      nxt_valid = 1'b1;
      nxt_port  = rel_port;
      nxt_stat  = rel_stat;
    end else begin
      nxt_valid = !mode_pess && is_ent;
      nxt_port  = pos;
      nxt_stat  = st_word;
    end
  end

  stq_port_table #(.MAX_PORTS(MAX_PORTS)) u_table (
    .clk(clk), .rst_n(rst_n), .wr_en(nxt_valid), .wr_port(nxt_port),
    .wr_stat(nxt_stat), .cal_len_m1(cal_len_m1), .ignore_bp(ignore_bp),
    .stop_all(stop_all)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upd_valid <= 1'b0;
      upd_port  <= '0;
      upd_stat  <= 2'b00;
      dip_seen  <= 1'b0;
      dip_err   <= 1'b0;
    end else begin
      upd_valid <= nxt_valid;
      upd_port  <= nxt_port;
      upd_stat  <= nxt_stat;
      dip_seen  <= is_dip;
      dip_err   <= is_dip && !dip_good;
    end
  end

  AST_DIP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    is_dip |=> dip_seen);  // R5
  AST_ERR_WITH_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
    dip_err |-> dip_seen);  // R5
  AST_FAST_FORWARD: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_pess && is_ent && !rel_valid) |=>
      (upd_valid && upd_stat == $past(st_word) && upd_port == $past(pos)));  // R2
  AST_HOLD_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_pess && !rel_valid) |=> !upd_valid);  // R6
  AST_BAD_NO_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (is_dip && !dip_good && !rel_valid) |=> !rel_valid);  // R7
endmodule

// File: tb/stat_qualifier_tb.sv
`timescale 1ns/1ps
module stat_qualifier_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_pess = 1'b0, ignore_bp = 1'b0;
  logic [3:0] cal_len_m1 = 4'd0;
  logic [1:0] cal_mult_m1 = 2'd0;
  logic       st_valid = 1'b0, st_dip = 1'b0;
  logic [1:0] st_word = 2'b00;
  logic       upd_valid, dip_seen, dip_err, stop_all;
  logic [3:0] upd_port;
  logic [1:0] upd_stat;

  stat_qualifier u_dut (
    .clk(clk), .rst_n(rst_n), .mode_pess(mode_pess), .ignore_bp(ignore_bp),
    .cal_len_m1(cal_len_m1), .cal_mult_m1(cal_mult_m1), .st_valid(st_valid),
    .st_word(st_word), .st_dip(st_dip), .upd_valid(upd_valid), .upd_port(upd_port),
    .upd_stat(upd_stat), .dip_seen(dip_seen), .dip_err(dip_err), .stop_all(stop_all)
  );

  always #2.5 clk = ~clk;

  int nchk = 0, nerr = 0, cyc = 0;
  int log_n = 0, log_port [128], log_stat [128], log_cyc [128], log_stop [128];
  int dip_n = 0, dip_cyc_seen = 0, dip_err_seen = 0;
  int fv [64], ecyc [64];

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) if (rst_n) begin
    if (upd_valid && log_n < 128) begin
      log_port[log_n] = int'(upd_port); log_stat[log_n] = int'(upd_stat);
      log_cyc[log_n] = cyc; log_stop[log_n] = int'(stop_all); log_n++;
    end
    if (dip_seen) begin dip_n++; dip_cyc_seen = cyc; dip_err_seen = int'(dip_err); end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin nerr++; $display("FAIL %s: actual %0d expected %0d", req, act, exp); end
  endtask

  task automatic put(input logic v, input logic [1:0] w, input logic d);
    @(negedge clk); st_valid = v; st_word = w; st_dip = d;
  endtask

  task automatic clear_logs();
    log_n = 0; dip_n = 0;
  endtask

  // Framing word, (len*mult - short_by) words from fv, then a parity word.
  task automatic send_frame(input int len, input int mult, input int corrupt,
                            input int short_by, output int dcyc);
    logic [1:0] acc;
    @(negedge clk); cal_len_m1 = 4'(len - 1); cal_mult_m1 = 2'(mult - 1);
    put(1'b1, 2'b11, 1'b0);
    acc = 2'b11;
    for (int i = 0; i < len * mult - short_by; i++) begin
      put(1'b1, 2'(fv[i]), 1'b0);
      ecyc[i] = cyc + 1;
      acc = {acc[0], acc[1]} ^ 2'(fv[i]);
    end
    put(1'b1, ~acc ^ 2'(corrupt), 1'b1);
    dcyc = cyc + 1;
    put(1'b0, 2'b00, 1'b0);
    repeat (len + 4) @(negedge clk);
  endtask

  task automatic t_reset();
    check(upd_valid == 0 && dip_seen == 0 && dip_err == 0, "R10 outputs idle", int'(upd_valid), 0);
    check(stop_all == 0, "R10 stop after reset", int'(stop_all), 0);
  endtask

  task automatic t_fast_good();
    int dc; int vals [8] = '{0, 1, 2, 0, 1, 2, 0, 1};
    mode_pess = 1'b0; clear_logs();
    foreach (vals[i]) fv[i] = vals[i];
    send_frame(4, 2, 0, 0, dc);
    check(log_n == 8, "R2 update count", log_n, 8);
    for (int i = 0; i < 8 && i < log_n; i++) begin
      check(log_port[i] == i % 4, "R1 port mapping", log_port[i], i % 4);
      check(log_stat[i] == fv[i], "R2 forwarded value", log_stat[i], fv[i]);
      check(log_cyc[i] == ecyc[i], "R2 forward timing", log_cyc[i], ecyc[i]);
    end
    check(dip_n == 1 && dip_cyc_seen == dc, "R5 dip_seen timing", dip_cyc_seen, dc);
    check(dip_err_seen == 0, "R4 matching parity", dip_err_seen, 0);
    check(stop_all == 1, "R8 satisfied port stops all", int'(stop_all), 1);
  endtask

  task automatic t_fast_err();
    int dc;
    mode_pess = 1'b0; clear_logs();
    send_frame(4, 2, 1, 0, dc);
    check(log_n == 8, "R3 updates kept on error", log_n, 8);
    for (int i = 0; i < 8 && i < log_n; i++)
      check(log_stat[i] == fv[i], "R3 value unchanged", log_stat[i], fv[i]);
    check(dip_err_seen == 1 && dip_cyc_seen == dc, "R5 dip_err flagged", dip_err_seen, 1);
  endtask

  task automatic t_outside();
    mode_pess = 1'b0; clear_logs();
    put(1'b1, 2'b01, 1'b0); put(1'b1, 2'b00, 1'b0); put(1'b1, 2'b10, 1'b0);
    put(1'b0, 2'b00, 1'b0);
    repeat (3) @(negedge clk);
    check(log_n == 0, "R1 words outside frame ignored", log_n, 0);
  endtask

  task automatic t_clear_stop();
    int dc;
    mode_pess = 1'b0; clear_logs();
    for (int i = 0; i < 4; i++) fv[i] = 0;
    send_frame(4, 1, 0, 0, dc);
    check(stop_all == 0, "R8 stop released when all starving", int'(stop_all), 0);
  endtask

  task automatic t_hold_good();
    int dc; int vals [6] = '{1, 1, 0, 2, 0, 1};
    mode_pess = 1'b1; clear_logs();
    foreach (vals[i]) fv[i] = vals[i];
    send_frame(3, 2, 0, 0, dc);
    check(log_n == 3, "R6 release count", log_n, 3);
    for (int k = 0; k < 3 && k < log_n; k++) begin
      check(log_port[k] == k, "R6 ascending order", log_port[k], k);
      check(log_stat[k] == fv[3 + k], "R6 last pass value", log_stat[k], fv[3 + k]);
      check(log_cyc[k] == dc + 1 + k, "R6 release timing", log_cyc[k], dc + 1 + k);
    end
    if (log_n > 0)
      check(log_stop[0] == 1, "R8 stop with the update", log_stop[0], 1);
    check(dip_err_seen == 0 && dip_cyc_seen == dc, "R5 dip_seen in hold mode", dip_err_seen, 0);
  endtask

  task automatic t_hold_bad();
    int dc;
    mode_pess = 1'b1; clear_logs();
    for (int i = 0; i < 3; i++) fv[i] = 0;
    send_frame(3, 1, 2, 0, dc);
    check(log_n == 0, "R7 nothing released", log_n, 0);
    check(stop_all == 1, "R7 table untouched", int'(stop_all), 1);
    check(dip_err_seen == 1, "R5 dip_err in hold mode", dip_err_seen, 1);
  endtask

  task automatic t_ignore();
    @(negedge clk); ignore_bp = 1'b1;
    @(negedge clk);
    check(stop_all == 0, "R9 ignore forces low", int'(stop_all), 0);
    ignore_bp = 1'b0;
    @(negedge clk);
    check(stop_all == 1, "R8 stop returns", int'(stop_all), 1);
  endtask

  task automatic t_short();
    int dc;
    mode_pess = 1'b1; clear_logs();
    for (int i = 0; i < 6; i++) fv[i] = 1;
    send_frame(3, 2, 0, 1, dc);
    check(dip_err_seen == 1, "R4 wrong count is an error", dip_err_seen, 1);
    check(log_n == 0, "R7 short frame not released", log_n, 0);
  endtask

  task automatic t_no_frame();
    clear_logs();
    put(1'b1, 2'b00, 1'b1); put(1'b0, 2'b00, 1'b0);
    repeat (2) @(negedge clk);
    check(dip_n == 1 && dip_err_seen == 1, "R4 parity without frame", dip_err_seen, 1);
  endtask

  initial begin
    #20000000;
    nerr++; $display("FAIL watchdog: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fast_good();
    t_fast_err();
    t_outside();
    t_clear_stop();
    t_hold_good();
    t_hold_bad();
    t_ignore();
    t_short();
    t_no_frame();
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule